// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block keeps the timing state of every bank in one SDRAM rank so that a memory controller's scheduler can see, cycle by cycle, which commands are legal. The scheduler reports each command it actually issues (activate, read, write, precharge or refresh) together with the target bank and, for an activate, the row. From that history the block raises per-bank permit flags for activate, read/write and precharge, plus one rank-wide permit for refresh.

Each bank also runs an open-page timer. An activate, read or write to that bank restarts the timer, so page hits keep the row open. When the timer runs out on an open bank, the block raises a precharge request for that bank, and the request stays up until a precharge is issued. Every interval comes from a configuration input and is counted in memory clock cycles. Choosing between requests and encoding the command pins are left to the surrounding controller.

Top module: `sdr_bank_timer`

## Requirements
- R1: After a synchronous active-high reset, all banks are closed, every activate permit and the refresh permit are 1, and every read/write permit, precharge permit and precharge request is 0.
- R2: The command code on `cmd` is 1 for activate, 2 for read, 3 for write, 4 for precharge and 5 for refresh. An activate opens the addressed bank and stores `cmd_row` as its open row. A precharge closes the addressed bank.
- R3: If an activate to bank b is issued in cycle t with `cfg_act_rw` = N, then `ok_rw[b]` is 0 in cycles t+1 to t+N-1 and 1 from cycle t+N for as long as the bank stays open.
- R4: If an activate to bank b is issued in cycle t with `cfg_act_pre` = N, then `ok_pre[b]` is 0 before cycle t+N and 1 from cycle t+N while the bank is open.
- R5: If a precharge to bank b is issued in cycle t with `cfg_pre_act` = N, then `ok_act[b]` is 0 before cycle t+N and may be 1 from t+N on. An open bank never has its activate permit set.
- R6: If an activate to any bank is issued in cycle t with `cfg_act_act` = N, then no bank's activate permit is 1 before cycle t+N.
- R7: `ok_ref` is 1 only when every bank is closed and the precharge-to-activate interval of every bank has run out.
- R8: Activate, read and write to bank b load its page timer with `cfg_page` = N. If no further access follows the last one, issued in cycle t, then `pre_req[b]` rises in cycle t+N and stays at 1 until a precharge to b is issued. It is 0 in the cycle after that precharge.
- R9: An interval setting of 0 acts as 1, so a dependent permit is never 1 in the cycle of the command it depends on, and it is 1 in the next cycle.
- R10: Command codes 0, 6 and 7 change no state. They reload no timer, open or close no bank, and leave every permit and request unchanged.
- R11: Commands to one bank leave the open state, read/write permit and precharge permit of the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command issued this cycle (0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh) |
| cmd_bank | input | BANK_W | Target bank of the issued command |
| cmd_row | input | ROW_W | Row address carried by an activate |
| cfg_act_act | input | TIME_W | Activate-to-activate interval, any two banks |
| cfg_act_pre | input | TIME_W | Activate-to-precharge interval, same bank |
| cfg_act_rw | input | TIME_W | Activate-to-read/write interval, same bank |
| cfg_pre_act | input | TIME_W | Precharge-to-activate/refresh interval, same bank |
| cfg_page | input | PAGE_W | Page-open duration after each access |
| ok_act | output | NUM_BANKS | Activate permitted per bank |
| ok_rw | output | NUM_BANKS | Read or write permitted per bank |
| ok_pre | output | NUM_BANKS | Precharge permitted per bank |
| ok_ref | output | 1 | Refresh permitted for the rank |
| pre_req | output | NUM_BANKS | Page timer expired, precharge wanted per bank |
| bank_open | output | NUM_BANKS | Bank has an open row |
| open_rows | output | NUM_BANKS*ROW_W | Open row of each bank, bank 0 in the low bits |

## Verification
The timing permits are stepped cycle by cycle after single activate and precharge commands with distinct non-zero settings. Because the settings differ, an off-by-one in any counter, or a swap between two intervals, shows up in a specific cycle. One pattern places a read partway through the page window, which separates a timer that reloads on page hits from one that counts only from the activate. A second pattern sends unused command codes partway through, which shows whether those codes wrongly restart the timer. With all settings at zero, the 0-as-1 rule is checked against a literal zero-cycle interval. Refresh is checked while a bank is open and during the precharge recovery, so the all-closed condition and the recovery time are each tested on their own.

// File: rtl/sdr_bank_timing_pkg.sv
package sdr_bank_timing_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic refr;
    } cmd_dec_t;

    typedef struct packed {
        logic is_open;
        logic act_local_ok;
        logic rw_ok;
        logic pre_ok;
        logic rp_done;
        logic page_expired;
    } bank_stat_t;

    function automatic cmd_dec_t decode_cmd(input logic [2:0] code);
        cmd_dec_t d;
        d      = '0;
        d.act  = (code == CMD_ACT);
        d.rd   = (code == CMD_RD);
        d.wr   = (code == CMD_WR);
        d.pre  = (code == CMD_PRE);
        d.refr = (code == CMD_REF);
        return d;
    endfunction

endpackage

// File: rtl/sdr_interval_cnt.sv
module sdr_interval_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] remain;
    logic [W-1:0] load_val;

    // A setting of zero behaves like one: the dependent command waits one cycle.
    always_comb load_val = (len == '0) ? '0 : (len - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - ONE;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot
    import sdr_bank_timing_pkg::*;
#(
    parameter int TIME_W = 5,
    parameter int PAGE_W = 8,
    parameter int ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_dec_t          dec,
    input  logic              hit,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [TIME_W-1:0] cfg_act_pre,
    input  logic [TIME_W-1:0] cfg_act_rw,
    input  logic [TIME_W-1:0] cfg_pre_act,
    input  logic [PAGE_W-1:0] cfg_page,
    output bank_stat_t        stat,
    output logic [ROW_W-1:0]  row_q
);
    logic act_here, acc_here, pre_here;
    logic ras_done, rcd_done, rp_done, page_done;
    logic open_q;

    always_comb begin
        act_here = hit && dec.act;
        acc_here = hit && (dec.rd || dec.wr);
        pre_here = hit && dec.pre;
    end

    sdr_interval_cnt #(.W(TIME_W)) u_ras (
        .clk(clk), .rst(rst), .load(act_here), .len(cfg_act_pre), .expired(ras_done));
    sdr_interval_cnt #(.W(TIME_W)) u_rcd (
        .clk(clk), .rst(rst), .load(act_here), .len(cfg_act_rw), .expired(rcd_done));
    sdr_interval_cnt #(.W(TIME_W)) u_rp (
        .clk(clk), .rst(rst), .load(pre_here), .len(cfg_pre_act), .expired(rp_done));
    sdr_interval_cnt #(.W(PAGE_W)) u_page (
        .clk(clk), .rst(rst), .load(act_here || acc_here), .len(cfg_page), .expired(page_done));

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (act_here) begin
            open_q <= 1'b1;
            row_q  <= row_in;
        end else if (pre_here) begin
            open_q <= 1'b0;
        end
    end

    always_comb begin
        stat.is_open      = open_q;
        stat.act_local_ok = !open_q && rp_done;
        stat.rw_ok        = open_q && rcd_done;
        stat.pre_ok       = open_q && ras_done;
        stat.rp_done      = rp_done;
        stat.page_expired = open_q && page_done;
    end
endmodule

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer
    import sdr_bank_timing_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int TIME_W = 5,
    parameter int PAGE_W = 8,
    parameter int ROW_W  = 13,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 cmd,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    input  logic [TIME_W-1:0]          cfg_act_act,
    input  logic [TIME_W-1:0]          cfg_act_pre,
    input  logic [TIME_W-1:0]          cfg_act_rw,
    input  logic [TIME_W-1:0]          cfg_pre_act,
    input  logic [PAGE_W-1:0]          cfg_page,
    output logic [NUM_BANKS-1:0]       ok_act,
    output logic [NUM_BANKS-1:0]       ok_rw,
    output logic [NUM_BANKS-1:0]       ok_pre,
    output logic                       ok_ref,
    output logic [NUM_BANKS-1:0]       pre_req,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows
);
    cmd_dec_t   dec;
    logic       rrd_done;
    bank_stat_t stat [NUM_BANKS];
    logic [NUM_BANKS-1:0] rp_ready;

    always_comb dec = decode_cmd(cmd);

    // Rank-wide activate spacing, restarted by an activate to any bank.
    sdr_interval_cnt #(.W(TIME_W)) u_rrd (
        .clk(clk), .rst(rst), .load(dec.act), .len(cfg_act_act), .expired(rrd_done));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [ROW_W-1:0] row_b;

        sdr_bank_slot #(.TIME_W(TIME_W), .PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_slot (
            .clk(clk),
            .rst(rst),
            .dec(dec),
            .hit(cmd_bank == BANK_W'(b)),
            .row_in(cmd_row),
            .cfg_act_pre(cfg_act_pre),
            .cfg_act_rw(cfg_act_rw),
            .cfg_pre_act(cfg_pre_act),
            .cfg_page(cfg_page),
            .stat(stat[b]),
            .row_q(row_b)
        );

        always_comb begin
            ok_act[b]    = stat[b].act_local_ok && rrd_done;
            ok_rw[b]     = stat[b].rw_ok;
            ok_pre[b]    = stat[b].pre_ok;
            pre_req[b]   = stat[b].page_expired;
            bank_open[b] = stat[b].is_open;
            rp_ready[b]  = stat[b].rp_done;
        end

        assign open_rows[b*ROW_W +: ROW_W] = row_b;
    end

    always_comb ok_ref = (bank_open == '0) && (&rp_ready);
endmodule

// File: rtl/sdr_bank_timer_chk.sv
module sdr_bank_timer_chk #(
    parameter int BANK_W = 2,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           cmd,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic [NUM_BANKS-1:0] ok_act,
    input logic [NUM_BANKS-1:0] ok_rw,
    input logic [NUM_BANKS-1:0] ok_pre,
    input logic                 ok_ref,
    input logic [NUM_BANKS-1:0] pre_req,
    input logic [NUM_BANKS-1:0] bank_open
);
    assert_ref_closed_R7: assert property (@(posedge clk) disable iff (rst)
        ok_ref |-> (bank_open == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        assert_act_on_closed_R5: assert property (@(posedge clk) disable iff (rst)
            ok_act[b] |-> !bank_open[b]);
        assert_rw_on_open_R3: assert property (@(posedge clk) disable iff (rst)
            ok_rw[b] |-> bank_open[b]);
        assert_pre_on_open_R4: assert property (@(posedge clk) disable iff (rst)
            ok_pre[b] |-> bank_open[b]);
        assert_req_on_open_R8: assert property (@(posedge clk) disable iff (rst)
            pre_req[b] |-> bank_open[b]);
        assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
            (cmd == 3'd1 && cmd_bank == BANK_W'(b)) |=> (bank_open[b] && !ok_act[b]));
        assert_pre_closes_R2: assert property (@(posedge clk) disable iff (rst)
            (cmd == 3'd4 && cmd_bank == BANK_W'(b)) |=> (!bank_open[b] && !pre_req[b]));
    end
endmodule

bind sdr_bank_timer sdr_bank_timer_chk #(.BANK_W(BANK_W)) u_chk (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank),
    .ok_act(ok_act), .ok_rw(ok_rw), .ok_pre(ok_pre), .ok_ref(ok_ref),
    .pre_req(pre_req), .bank_open(bank_open)
);

// File: tb/sdr_bank_timer_test.sv
`timescale 1ns/1ps
module sdr_bank_timer_test;
    import sdr_bank_timing_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  cmd_bank = '0;
    logic [12:0] cmd_row = '0;
    logic [4:0]  cfg_act_act = 5'd2;
    logic [4:0]  cfg_act_pre = 5'd5;
    logic [4:0]  cfg_act_rw  = 5'd3;
    logic [4:0]  cfg_pre_act = 5'd4;
    logic [7:0]  cfg_page    = 8'd40;
    logic [3:0]  ok_act, ok_rw, ok_pre, pre_req, bank_open;
    logic        ok_ref;
    logic [51:0] open_rows;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sdr_bank_timer uut (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cfg_act_act(cfg_act_act), .cfg_act_pre(cfg_act_pre), .cfg_act_rw(cfg_act_rw),
        .cfg_pre_act(cfg_pre_act), .cfg_page(cfg_page),
        .ok_act(ok_act), .ok_rw(ok_rw), .ok_pre(ok_pre), .ok_ref(ok_ref),
        .pre_req(pre_req), .bank_open(bank_open), .open_rows(open_rows)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge (k = 1).
    task automatic issue(input logic [2:0] c, input int b, input logic [12:0] r);
        cmd = c; cmd_bank = b[1:0]; cmd_row = r;
        @(negedge clk);
        cmd = CMD_NOP;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "ok_act", ok_act, 4'hF);
        check("R1", "ok_ref", ok_ref, 1);
        check("R1", "ok_rw", ok_rw, 0);
        check("R1", "ok_pre", ok_pre, 0);
        check("R1", "pre_req", pre_req, 0);
        check("R1", "bank_open", bank_open, 0);
    endtask

    task automatic t_act_timing;
        issue(CMD_ACT, 0, 13'h1A5);
        check("R2", "open_row0", open_rows[12:0], 13'h1A5);
        for (int k = 1; k <= 6; k++) begin
            check("R3", $sformatf("ok_rw0 k=%0d", k), ok_rw[0], k >= 3);
            check("R4", $sformatf("ok_pre0 k=%0d", k), ok_pre[0], k >= 5);
            check("R6", $sformatf("ok_act1 k=%0d", k), ok_act[1], k >= 2);
            check("R5", "ok_act0 while open", ok_act[0], 0);
            check("R2", "bank_open0", bank_open[0], 1);
            check("R11", "bank1 untouched", {bank_open[1], ok_rw[1], ok_pre[1]}, 0);
            step(1);
        end
    endtask

    task automatic t_pre_timing;
        issue(CMD_PRE, 0, 13'h0);
        for (int k = 1; k <= 5; k++) begin
            check("R2", "bank_open0 after pre", bank_open[0], 0);
            check("R5", $sformatf("ok_act0 k=%0d", k), ok_act[0], k >= 4);
            check("R7", $sformatf("ok_ref k=%0d", k), ok_ref, k >= 4);
            step(1);
        end
    endtask

    task automatic t_ref_gate;
        issue(CMD_ACT, 2, 13'h0F0);
        for (int k = 1; k <= 6; k++) begin
            check("R7", $sformatf("ok_ref bank open k=%0d", k), ok_ref, 0);
            step(1);
        end
        issue(CMD_PRE, 2, 13'h0);
        for (int k = 1; k <= 5; k++) begin
            check("R7", $sformatf("ok_ref recovery k=%0d", k), ok_ref, k >= 4);
            step(1);
        end
    endtask

    task automatic t_page_reload;
        cfg_page = 8'd6;
        issue(CMD_ACT, 1, 13'h022);
        for (int k = 1; k <= 3; k++) begin
            check("R8", "pre_req1 before hit", pre_req[1], 0);
            step(1);
        end
        issue(CMD_RD, 1, 13'h0);
        for (int k = 1; k <= 8; k++) begin
            check("R8", $sformatf("pre_req1 k=%0d", k), pre_req[1], k >= 6);
            step(1);
        end
        issue(CMD_PRE, 1, 13'h0);
        check("R8", "pre_req1 after pre", pre_req[1], 0);
        step(4);
        cfg_page = 8'd40;
    endtask

    task automatic t_zero_settings;
        cfg_act_act = 0; cfg_act_pre = 0; cfg_act_rw = 0; cfg_pre_act = 0; cfg_page = 0;
        issue(CMD_ACT, 3, 13'h111);
        check("R9", "ok_rw3 k=1", ok_rw[3], 1);
        check("R9", "ok_pre3 k=1", ok_pre[3], 1);
        check("R9", "ok_act0 k=1", ok_act[0], 1);
        check("R9", "pre_req3 k=1", pre_req[3], 1);
        issue(CMD_PRE, 3, 13'h0);
        check("R9", "ok_act3 k=1", ok_act[3], 1);
        check("R9", "ok_ref k=1", ok_ref, 1);
        cfg_act_act = 5'd2; cfg_act_pre = 5'd5; cfg_act_rw = 5'd3;
        cfg_pre_act = 5'd4; cfg_page = 8'd40;
        step(1);
    endtask

    task automatic t_ignored_codes;
        cfg_page = 8'd6;
        issue(CMD_ACT, 0, 13'h077);
        step(2);
        issue(3'd6, 0, 13'h0);
        issue(3'd7, 0, 13'h0);
        check("R10", "pre_req0 k=5", pre_req[0], 0);
        check("R10", "bank_open0", bank_open[0], 1);
        check("R10", "ok_pre0 k=5", ok_pre[0], 1);
        check("R10", "ok_rw0 k=5", ok_rw[0], 1);
        check("R10", "open_row0", open_rows[12:0], 13'h077);
        step(1);
        check("R10", "pre_req0 k=6", pre_req[0], 1);
        issue(CMD_PRE, 0, 13'h0);
        step(4);
        cfg_page = 8'd40;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_act_timing();
        t_pre_timing();
        t_ref_gate();
        t_page_reload();
        t_zero_settings();
        t_ignored_codes();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule